// File: doc/BRIEF.md
# Byte-Port Command Mailbox Host Sequencer

This block is a hardware master that carries one command packet into a byte-wide security coprocessor and then collects that device's response packet. The device has two byte addresses. Address 0 is the data register. Address 1 returns status when read and takes command codes when written. The sequencer drives these addresses through a simple request/acknowledge bus and runs the complete framed handshake. It forces a cancel, waits for the device to be ready, opens the packet with a start marker, paces every byte on the device's flow-control flags, and closes the packet with an end marker. It then reads the reply, checking its start marker, until an end flag appears, and checks the closing marker.

A client loads a packet into a byte source and starts the transfer with `xfer_start`. The sequencer fetches payload bytes through `tx_addr`/`tx_data`. Response bytes go to a sink through `rx_we`/`rx_addr`/`rx_wdata`. When the transfer ends, the block pulses `done`, or pulses `fail` with a reason code. The response length, which is stored big-endian in response bytes 2 to 5, is presented on `resp_len`. When idle, the client can pulse `cancel_req` to issue a lone cancel command.

States: `S_IDLE`, `S_SOLO_CAN` (lone cancel write), `S_CAN_WR` (transfer's leading cancel), `S_RDY_POLL` / `S_RDY_DRAIN` (ready wait, discarding stale output), `S_IBF0_POLL`, `S_SOC_WR`, `S_IBR_POLL`, `S_BYTE_IBF` / `S_BYTE_WR` (payload loop), `S_EOC_IBF`, `S_EOC_WR`, `S_F0_POLL`, `S_SOM_RD`, `S_OBF_POLL` / `S_DATA_RD` (response loop), `S_EOM_RD`, `S_DONE`, `S_FAIL`.

Transitions: idle goes to the leading cancel on start, or to the lone cancel on a cancel request. Every write or read advances on acknowledge. A poll state advances when its status condition holds and otherwise repeats the read. Any poll that reaches its timeout goes to `S_FAIL`. A bad marker or a sink overflow also goes to `S_FAIL`. `S_DONE` and `S_FAIL` return to idle after one cycle.

Top module: `mbox_host_seq`

## Requirements
- R1: After reset the block is idle. `bus_req`, `busy`, `done` and `fail` are low and `fail_code` is 0.
- R2: A `cancel_req` pulse while idle, with no `xfer_start`, produces exactly one write of 0x22 to address 1. No other bus access follows, and the block returns to idle without pulsing `done` or `fail`.
- R3: A transfer's first bus access is a write of 0x22 to address 1. When `xfer_start` and `cancel_req` arrive in the same cycle, the transfer takes priority and only that single cancel is written.
- R4: After the cancel, status (address 1) is polled. Whenever bit 0 (output full) is set, one read of address 0 is made and its value discarded. The wait ends when bit 4 (ready) is seen. If ready is not seen within SHORT_TMO cycles, the transfer fails with code 1.
- R5: Before the 0x01 start write, before each payload byte and before the 0x03 end write, status is polled until bit 1 (input full) is clear. If any of these waits exceeds LONG_TMO cycles, the transfer fails with code 2.
- R6: After the 0x01 start write, status is polled until bit 5 (ready for data) is set. If this exceeds LONG_TMO cycles, the transfer fails with code 3.
- R7: The payload bytes `tx_data` at `tx_addr` 0 to `tx_len`-1 are written to address 0 in ascending order. When `tx_len` is 0, no data is written and the block goes straight to the end wait. The command writes are exactly 0x22, 0x01, 0x03 in that order.
- R8: After the 0x03 write, status is polled until bit 2 (end flag F0) is set. The next data read must then return 0x01, otherwise the transfer fails with code 5. A receive-side status wait that exceeds LONG_TMO fails with code 4.
- R9: In the response loop, a status sample with bit 0 set and bit 2 clear causes one data read, which is written to the sink at the next index. A sample with bits 0 and 2 both set ends the loop without a data read.
- R10: After the loop ends, the next data read must return 0x03, otherwise the transfer fails with code 6. On success `done` pulses with `fail_code` 0 and `rx_count` equal to the number of response bytes.
- R11: If the device offers more than RX_DEPTH response bytes, the transfer fails with code 7 and no sink write is made at index RX_DEPTH or above.
- R12: `resp_len` equals response bytes 2, 3, 4, 5 taken as a big-endian 32-bit value.
- R13: A raised `bus_req` keeps `bus_addr`, `bus_wr` and `bus_wdata` steady until `bus_ack`, unless the transfer fails on a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start a send-and-receive transfer (accepted when idle) |
| cancel_req | input | 1 | Issue a lone cancel command (accepted when idle) |
| tx_len | input | TX_LEN_W | Payload byte count, sampled at start |
| tx_addr | output | TX_LEN_W | Index of the payload byte wanted |
| tx_data | input | 8 | Payload byte at `tx_addr` |
| rx_we | output | 1 | Sink write strobe |
| rx_addr | output | RX_AW | Sink write index |
| rx_wdata | output | 8 | Sink write byte |
| rx_count | output | RX_AW | Response bytes stored (valid with `done`) |
| resp_len | output | 32 | Big-endian length from response bytes 2 to 5 |
| busy | output | 1 | High whenever not idle |
| done | output | 1 | One-cycle pulse on success |
| fail | output | 1 | One-cycle pulse on failure |
| fail_code | output | 3 | Failure reason, held until the next start |
| bus_req | output | 1 | Device access request |
| bus_wr | output | 1 | Access is a write |
| bus_addr | output | 1 | 0 selects data, 1 selects status/command |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |

## Verification
Two functions can fall in the same cycle. The first pair is a start and a lone cancel request: the bench raises `xfer_start` and `cancel_req` together while idle and judges the outcome from the logged command writes, which must be exactly 0x22, 0x01, 0x03 with no second cancel. The second pair is the data-available flag and the end flag in one status sample. The device model presents both bits at once after the last response byte, and the bench requires that no extra data read occurs, that `rx_count` equals the bytes offered and that the closing marker check still passes. Random packet lengths, flow-control stalls and stale output bytes are mixed with directed timeout, bad-marker and overflow cases.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_SOLO_CAN,
        S_CAN_WR,
        S_RDY_POLL,
        S_RDY_DRAIN,
        S_IBF0_POLL,
        S_SOC_WR,
        S_IBR_POLL,
        S_BYTE_IBF,
        S_BYTE_WR,
        S_EOC_IBF,
        S_EOC_WR,
        S_F0_POLL,
        S_SOM_RD,
        S_OBF_POLL,
        S_DATA_RD,
        S_EOM_RD,
        S_DONE,
        S_FAIL
    } state_e;

    typedef enum logic [2:0] {
        E_NONE = 3'd0,
        E_RDY  = 3'd1,
        E_IBF  = 3'd2,
        E_IBR  = 3'd3,
        E_F0   = 3'd4,
        E_SOM  = 3'd5,
        E_EOM  = 3'd6,
        E_OVF  = 3'd7
    } err_e;

    localparam logic [7:0] CMD_SOC = 8'h01;
    localparam logic [7:0] CMD_EOC = 8'h03;
    localparam logic [7:0] CMD_CAN = 8'h22;

    // status bit positions decoded from the device
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_F0  = 2;
    localparam int ST_RDY = 4;
    localparam int ST_IBR = 5;

endpackage

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
    parameter int LONG_TMO  = 1000000,
    parameter int SHORT_TMO = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic short_sel,
    output logic expired
);
    localparam int MAXV = (LONG_TMO > SHORT_TMO) ? LONG_TMO : SHORT_TMO;
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = short_sel ? (cnt_q >= CW'(SHORT_TMO)) : (cnt_q >= CW'(LONG_TMO));
endmodule

// File: rtl/mbox_len_capture.sv
module mbox_len_capture #(
    parameter int AW     = 5,
    parameter int FIRST  = 2,
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [7:0]            data,
    output logic [8*NBYTES-1:0]   len_o
);
    localparam int LAST = FIRST + NBYTES - 1;

    logic in_window;
    assign in_window = (int'(addr) >= FIRST) && (int'(addr) <= LAST);

    // bytes arrive in index order, so shifting left builds a big-endian value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_o <= '0;
        else if (clr)
            len_o <= '0;
        else if (we && in_window)
            len_o <= {len_o[8*NBYTES-9:0], data};
    end
endmodule

// File: rtl/mbox_host_seq.sv
module mbox_host_seq
    import mbox_pkg::*;
#(
    parameter int TX_LEN_W  = 12,
    parameter int RX_DEPTH  = 64,
    parameter int LONG_TMO  = 1000000,
    parameter int SHORT_TMO = 10000,
    localparam int RX_AW    = $clog2(RX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_start,
    input  logic                cancel_req,
    input  logic [TX_LEN_W-1:0] tx_len,
    output logic [TX_LEN_W-1:0] tx_addr,
    input  logic [7:0]          tx_data,
    output logic                rx_we,
    output logic [RX_AW-1:0]    rx_addr,
    output logic [7:0]          rx_wdata,
    output logic [RX_AW-1:0]    rx_count,
    output logic [31:0]         resp_len,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [2:0]          fail_code,
    output logic                bus_req,
    output logic                bus_wr,
    output logic                bus_addr,
    output logic [7:0]          bus_wdata,
    input  logic                bus_ack,
    input  logic [7:0]          bus_rdata
);
    localparam int IDX_W = (TX_LEN_W > RX_AW) ? TX_LEN_W : RX_AW;

    state_e            state_q, state_d;
    err_e              err_d;
    logic [2:0]        code_q;
    logic [IDX_W-1:0]  idx_q, len_q;
    logic              tmo_hit, tmo_clr, tmo_en, tmo_short;
    logic              take_start;

    function automatic logic in_rdy_grp(state_e s);
        return (s == S_RDY_POLL) || (s == S_RDY_DRAIN);
    endfunction

    assign take_start = (state_q == S_IDLE) && xfer_start;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            len_q  <= '0;
            code_q <= E_NONE;
        end else begin
            if (take_start) begin
                idx_q  <= '0;
                len_q  <= IDX_W'(tx_len);
                code_q <= E_NONE;
            end else if (bus_ack && (state_q == S_BYTE_WR || state_q == S_DATA_RD)) begin
                idx_q <= idx_q + 1'b1;
            end else if (bus_ack && state_q == S_EOC_WR) begin
                idx_q <= '0;
            end
            if (state_d == S_FAIL && state_q != S_FAIL)
                code_q <= err_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        err_d   = E_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (xfer_start)      state_d = S_CAN_WR;
                else if (cancel_req) state_d = S_SOLO_CAN;
            end
            S_SOLO_CAN:  if (bus_ack) state_d = S_IDLE;
            S_CAN_WR:    if (bus_ack) state_d = S_RDY_POLL;
            S_RDY_POLL: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_RDY;
                end else if (bus_ack && bus_rdata[ST_OBF]) state_d = S_RDY_DRAIN;
                else if (bus_ack && bus_rdata[ST_RDY])     state_d = S_IBF0_POLL;
            end
            S_RDY_DRAIN: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_RDY;
                end else if (bus_ack) state_d = S_RDY_POLL;
            end
            S_IBF0_POLL: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_IBF;
                end else if (bus_ack && !bus_rdata[ST_IBF]) state_d = S_SOC_WR;
            end
            S_SOC_WR:    if (bus_ack) state_d = S_IBR_POLL;
            S_IBR_POLL: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_IBR;
                end else if (bus_ack && bus_rdata[ST_IBR])
                    state_d = (len_q == '0) ? S_EOC_IBF : S_BYTE_IBF;
            end
            S_BYTE_IBF: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_IBF;
                end else if (bus_ack && !bus_rdata[ST_IBF]) state_d = S_BYTE_WR;
            end
            S_BYTE_WR: begin
                if (bus_ack)
                    state_d = ((idx_q + 1'b1) == len_q) ? S_EOC_IBF : S_BYTE_IBF;
            end
            S_EOC_IBF: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_IBF;
                end else if (bus_ack && !bus_rdata[ST_IBF]) state_d = S_EOC_WR;
            end
            S_EOC_WR:    if (bus_ack) state_d = S_F0_POLL;
            S_F0_POLL: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_F0;
                end else if (bus_ack && bus_rdata[ST_F0]) state_d = S_SOM_RD;
            end
            S_SOM_RD: begin
                if (bus_ack) begin
                    if (bus_rdata == CMD_SOC) state_d = S_OBF_POLL;
                    else begin
                        state_d = S_FAIL; err_d = E_SOM;
                    end
                end
            end
            S_OBF_POLL: begin
                if (tmo_hit) begin
                    state_d = S_FAIL; err_d = E_F0;
                end else if (bus_ack && bus_rdata[ST_OBF]) begin
                    if (bus_rdata[ST_F0])                 state_d = S_EOM_RD;
                    else if (idx_q == IDX_W'(RX_DEPTH)) begin
                        state_d = S_FAIL; err_d = E_OVF;
                    end else                              state_d = S_DATA_RD;
                end
            end
            S_DATA_RD:   if (bus_ack) state_d = S_OBF_POLL;
            S_EOM_RD: begin
                if (bus_ack) begin
                    if (bus_rdata == CMD_EOC) state_d = S_DONE;
                    else begin
                        state_d = S_FAIL; err_d = E_EOM;
                    end
                end
            end
            S_DONE:      state_d = S_IDLE;
            S_FAIL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = 1'b0;
        bus_wdata = 8'h00;
        tmo_en    = 1'b0;
        unique case (state_q)
            S_SOLO_CAN, S_CAN_WR: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_CAN;
            end
            S_SOC_WR: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_SOC;
            end
            S_EOC_WR: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = CMD_EOC;
            end
            S_BYTE_WR: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_wdata = tx_data;
            end
            S_RDY_POLL, S_IBF0_POLL, S_IBR_POLL, S_BYTE_IBF,
            S_EOC_IBF, S_F0_POLL, S_OBF_POLL: begin
                bus_req = 1'b1; bus_addr = 1'b1; tmo_en = 1'b1;
            end
            S_RDY_DRAIN: begin
                bus_req = 1'b1; tmo_en = 1'b1;
            end
            S_SOM_RD, S_DATA_RD, S_EOM_RD: bus_req = 1'b1;
            default: ;
        endcase
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        fail      = (state_q == S_FAIL);
        fail_code = code_q;
        tx_addr   = idx_q[TX_LEN_W-1:0];
        rx_we     = (state_q == S_DATA_RD) && bus_ack;
        rx_addr   = idx_q[RX_AW-1:0];
        rx_wdata  = bus_rdata;
        rx_count  = idx_q[RX_AW-1:0];
    end

    // the ready wait and its drain reads share one timeout window
    assign tmo_short = in_rdy_grp(state_q);
    assign tmo_clr   = (state_d != state_q) && !(in_rdy_grp(state_q) && in_rdy_grp(state_d));

    mbox_wait_timer #(
        .LONG_TMO  (LONG_TMO),
        .SHORT_TMO (SHORT_TMO)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmo_clr),
        .en        (tmo_en),
        .short_sel (tmo_short),
        .expired   (tmo_hit)
    );

    mbox_len_capture #(
        .AW     (RX_AW),
        .FIRST  (2),
        .NBYTES (4)
    ) len_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_start),
        .we    (rx_we),
        .addr  (rx_addr),
        .data  (rx_wdata),
        .len_o (resp_len)
    );
endmodule

// File: rtl/mbox_host_seq_chk.sv
module mbox_host_seq_chk #(
    parameter int RX_DEPTH = 64,
    localparam int RX_AW   = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             cancel_req,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic [2:0]       fail_code,
    input logic             bus_req,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             bus_ack,
    input logic             rx_we,
    input logic [RX_AW-1:0] rx_addr
);
    assert_solo_cancel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_req && !xfer_start && !busy) |=> (bus_req && bus_wr && bus_addr && bus_wdata == 8'h22));

    assert_start_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !busy) |=> (bus_req && bus_wr && bus_addr && bus_wdata == 8'h22));

    assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail_code == 3'd0 && !fail));

    assert_end_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !busy);

    assert_sink_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (bus_ack && !bus_wr && !bus_addr && int'(rx_addr) < RX_DEPTH));

    assert_bus_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (fail || (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata))));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);
endmodule

bind mbox_host_seq mbox_host_seq_chk #(.RX_DEPTH(RX_DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .cancel_req (cancel_req),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_code  (fail_code),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .rx_we      (rx_we),
    .rx_addr    (rx_addr)
);

// File: tb/mbox_host_seq_tb_top.sv
module mbox_host_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TXW   = 8;
    localparam int DEPTH = 16;
    localparam int RAW   = $clog2(DEPTH + 1);
    localparam int LTMO  = 300;
    localparam int STMO  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            xfer_start = 1'b0, cancel_req = 1'b0;
    logic [TXW-1:0]  tx_len = '0, tx_addr;
    logic [7:0]      tx_data;
    logic            rx_we;
    logic [RAW-1:0]  rx_addr, rx_count;
    logic [7:0]      rx_wdata;
    logic [31:0]     resp_len;
    logic            busy, done, fail;
    logic [2:0]      fail_code;
    logic            bus_req, bus_wr, bus_addr;
    logic [7:0]      bus_wdata;
    logic            bus_ack = 1'b0;
    logic [7:0]      bus_rdata = 8'h00;

    mbox_host_seq #(
        .TX_LEN_W (TXW), .RX_DEPTH (DEPTH), .LONG_TMO (LTMO), .SHORT_TMO (STMO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .xfer_start (xfer_start), .cancel_req (cancel_req),
        .tx_len (tx_len), .tx_addr (tx_addr), .tx_data (tx_data),
        .rx_we (rx_we), .rx_addr (rx_addr), .rx_wdata (rx_wdata), .rx_count (rx_count),
        .resp_len (resp_len), .busy (busy), .done (done), .fail (fail), .fail_code (fail_code),
        .bus_req (bus_req), .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_ack (bus_ack), .bus_rdata (bus_rdata)
    );

    // ---------------- bench state ----------------
    int nchk = 0, nfail = 0;
    logic [7:0] txmem  [0:255];
    logic [7:0] txlog  [0:255];
    logic [7:0] cmdlog [0:15];
    logic [7:0] resp   [0:31];
    logic [7:0] sink   [0:31];
    int ntx, ncmd, nwe, drained;
    int phase, stale, rdy_wait, ibr_wait, f0_wait, ridx, nresp;
    bit ibf_stuck;
    logic [7:0] som_b, eom_b;

    assign tx_data = txmem[tx_addr];

    always @(posedge clk) begin
        if (rx_we) begin
            sink[rx_addr] <= rx_wdata;
            nwe = nwe + 1;
        end
    end

    // device model: acknowledge one cycle after a request
    always @(posedge clk or negedge rst_n) begin
        logic [7:0] st;
        if (!rst_n) begin
            bus_ack <= 1'b0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            bus_ack <= 1'b1;
            st = 8'h00;
            if (bus_wr && bus_addr) begin
                if (ncmd < 16) cmdlog[ncmd] = bus_wdata;
                ncmd = ncmd + 1;
                if (bus_wdata == 8'h22) phase = 1;
                else if (bus_wdata == 8'h01) phase = 2;
                else if (bus_wdata == 8'h03) phase = 3;
            end else if (bus_wr) begin
                if (ntx < 256) txlog[ntx] = bus_wdata;
                ntx = ntx + 1;
            end else if (bus_addr) begin
                case (phase)
                    1: if (stale > 0) st[0] = 1'b1;
                       else if (rdy_wait > 0) rdy_wait = rdy_wait - 1;
                       else st[4] = 1'b1;
                    2: begin
                        st[1] = ibf_stuck || ($urandom % 3 == 0);
                        if (ibr_wait > 0) ibr_wait = ibr_wait - 1;
                        else st[5] = 1'b1;
                    end
                    3: if (f0_wait > 0) f0_wait = f0_wait - 1;
                       else st[2] = 1'b1;
                    4: if (ridx < nresp) st[0] = 1'($urandom % 2);
                       else begin st[0] = 1'b1; st[2] = 1'b1; end
                    default: ;
                endcase
                bus_rdata <= st;
            end else begin
                case (phase)
                    1: begin
                        if (stale > 0) begin stale = stale - 1; drained = drained + 1; end
                        bus_rdata <= 8'hEE;
                    end
                    3: begin bus_rdata <= som_b; phase = 4; ridx = 0; end
                    4: if (ridx < nresp) begin bus_rdata <= resp[ridx]; ridx = ridx + 1; end
                       else begin bus_rdata <= eom_b; phase = 0; end
                    default: bus_rdata <= 8'h00;
                endcase
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_len();
        return {resp[2], resp[3], resp[4], resp[5]};
    endfunction

    task automatic setup(input int len, input int nr, input int stl, input int rw,
                         input int iw, input int fw, input bit stuck);
        for (int i = 0; i < 256; i++) txmem[i] = 8'($urandom);
        for (int i = 0; i < 32; i++) begin resp[i] = 8'($urandom); sink[i] = 8'h00; end
        tx_len = TXW'(len); nresp = nr; stale = stl; rdy_wait = rw; ibr_wait = iw;
        f0_wait = fw; ibf_stuck = stuck; som_b = 8'h01; eom_b = 8'h03;
        ntx = 0; ncmd = 0; nwe = 0; drained = 0; phase = 0; ridx = 0;
    endtask

    bit got_done, got_fail;
    logic [2:0] got_code;

    task automatic run(input bit with_cancel);
        got_done = 0; got_fail = 0; got_code = 0;
        @(negedge clk);
        xfer_start = 1'b1; cancel_req = with_cancel;
        @(negedge clk);
        xfer_start = 1'b0; cancel_req = 1'b0;
        for (int c = 0; c < 5000; c++) begin
            if (done || fail) begin
                got_done = done; got_fail = fail; got_code = fail_code;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_good(input int len, input int stl, input string tag);
        chk({tag, " R10 done"}, 32'(got_done), 32'd1);
        chk({tag, " R10 code"}, 32'(got_code), 32'd0);
        chk({tag, " R7 cmd count"}, 32'(ncmd), 32'd3);
        chk({tag, " R3 first cmd"}, 32'(cmdlog[0]), 32'h22);
        chk({tag, " R7 start cmd"}, 32'(cmdlog[1]), 32'h01);
        chk({tag, " R7 end cmd"}, 32'(cmdlog[2]), 32'h03);
        chk({tag, " R7 byte count"}, 32'(ntx), 32'(len));
        for (int i = 0; i < len; i++) chk({tag, " R7 byte"}, 32'(txlog[i]), 32'(txmem[i]));
        chk({tag, " R4 drained"}, 32'(drained), 32'(stl));
        chk({tag, " R9 rx_count"}, 32'(rx_count), 32'(nresp));
        chk({tag, " R9 writes"}, 32'(nwe), 32'(nresp));
        for (int i = 0; i < nresp; i++) chk({tag, " R9 sink"}, 32'(sink[i]), 32'(resp[i]));
        chk({tag, " R12 resp_len"}, resp_len, exp_len());
    endtask

    task automatic check_fail(input int code, input string tag);
        chk({tag, " fail"}, 32'(got_fail), 32'd1);
        chk({tag, " code"}, 32'(got_code), 32'(code));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        setup(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 done/fail", 32'({done, fail}), 32'd0);
        chk("R1 fail_code", 32'(fail_code), 32'd0);

        // R2 lone cancel
        @(negedge clk); cancel_req = 1'b1;
        @(negedge clk); cancel_req = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 cmd count", 32'(ncmd), 32'd1);
        chk("R2 cancel code", 32'(cmdlog[0]), 32'h22);
        chk("R2 no data", 32'(ntx), 32'd0);
        chk("R2 idle", 32'(busy), 32'd0);

        // directed good transfer with stale drain, R4/R5/R6/R7/R12
        setup(5, 8, 2, 2, 2, 2, 0);
        run(0);
        check_good(5, 2, "dir");

        // R7 zero length, R9 single stop sample
        setup(0, 6, 0, 0, 0, 0, 0);
        run(0);
        check_good(0, 0, "zero R7");

        // R3 start and cancel in the same cycle
        setup(3, 6, 1, 1, 1, 1, 0);
        run(1);
        check_good(3, 1, "both R3");

        // R9 exactly RX_DEPTH bytes fits
        setup(2, DEPTH, 0, 0, 0, 0, 0);
        run(0);
        check_good(2, 0, "full R9");

        // random mix
        for (int k = 0; k < 8; k++) begin
            int l, s;
            l = $urandom % 21; s = $urandom % 3;
            setup(l, 6 + ($urandom % 11), s, $urandom % 4, $urandom % 3, $urandom % 4, 0);
            run(0);
            check_good(l, s, "rand");
        end

        // timeouts and bad markers
        setup(2, 6, 0, 100000, 0, 0, 0); run(0); check_fail(1, "R4 ready timeout");
        setup(2, 6, 0, 0, 0, 0, 1);      run(0); check_fail(2, "R5 ibf timeout");
        setup(2, 6, 0, 0, 100000, 0, 0); run(0); check_fail(3, "R6 ibr timeout");
        setup(2, 6, 0, 0, 0, 100000, 0); run(0); check_fail(4, "R8 f0 timeout");
        setup(2, 6, 0, 0, 0, 0, 0); som_b = 8'h05; run(0); check_fail(5, "R8 bad start");
        setup(2, 6, 0, 0, 0, 0, 0); eom_b = 8'h07; run(0); check_fail(6, "R10 bad end");
        setup(1, DEPTH + 1, 0, 0, 0, 0, 0); run(0); check_fail(7, "R11 overflow");
        chk("R11 sink writes", 32'(nwe), 32'(DEPTH));

        // recovery after failure
        setup(4, 7, 0, 0, 0, 0, 0);
        run(0);
        check_good(4, 0, "recover");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule